// File: doc/BRIEF.md
# Independent Integer Op Bypass at Issue

This issue-stage block lets one narrow case break program order in an otherwise in-order core. Once a long-latency floating-point op has been accepted and is outstanding, a younger integer op may issue ahead of it, provided the two share no register in any direction. Any other younger op, and any integer op that touches the FP op's registers, waits until the FP op retires.

A single scoreboard slot records the outstanding FP op's destination and both of its sources. A three-state controller tracks the slot. In IDLE nothing is outstanding. In HELD an FP op is outstanding and nothing has passed it. In PASSED at least one younger op has issued ahead of it. The transitions are: *accept* (IDLE to HELD, on an FP issue); *pass* (HELD to PASSED, on a grant while the FP op is outstanding); *retire* (HELD or PASSED to IDLE, on completion). When an FP op that was overtaken completes with an exception, a one-cycle flag is raised so that recovery logic outside this block can act. The grant and stall decisions are combinational from the current inputs and the registered scoreboard.

Top module: `indep_bypass_issue`

## Requirements
- R1: After reset, `sb_busy`, `yng_grant`, `yng_stall` and `exc_after_pass` are low and `fp_ready` is high.
- R2: While nothing is outstanding, `fp_issue` is accepted: the next cycle `sb_busy` is high and `sb_dst` equals the accepted destination. While busy, `fp_ready` is low and `fp_issue` is ignored, so `sb_dst` is unchanged.
- R3: While nothing is outstanding, a valid younger op of any kind is granted in the same cycle, unless `fp_issue` is high in that cycle, in which case it stalls.
- R4: While busy, a valid younger op of kind INT (code 0) that uses none of the scoreboard's registers is granted in the same cycle.
- R5: While busy, a younger op whose first or second source equals the scoreboard destination stalls (read after write).
- R6: While busy, a younger op whose destination equals the scoreboard destination stalls (write after write).
- R7: While busy, a younger op whose destination equals either scoreboard source stalls (write after read).
- R8: While busy, younger ops of kinds LOAD (1), STORE (2), BRANCH (3), FP (4) and the unused codes 5 to 7 always stall.
- R9: `fp_done` while busy clears `sb_busy` in the next cycle. The same cycle's grant decision still uses the outstanding entry. `fp_done` while idle has no effect.
- R10: `exc_after_pass` pulses for exactly one cycle, the cycle after `fp_done` with `fp_exc`, only if a younger op was granted while that FP op was outstanding (including the completing cycle). Otherwise it stays low.
- R11: `yng_stall` equals `yng_valid` and not `yng_grant`, and both stay low when `yng_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_issue | input | 1 | Long-latency FP op is issuing |
| fp_dst | input | REG_W | FP op destination register |
| fp_src_a | input | REG_W | FP op first source |
| fp_src_b | input | REG_W | FP op second source |
| fp_ready | output | 1 | Scoreboard slot is free |
| fp_done | input | 1 | Outstanding FP op completes |
| fp_exc | input | 1 | Completing FP op raised an exception |
| yng_valid | input | 1 | Younger op presented for issue |
| yng_kind | input | 3 | Younger op kind code |
| yng_src_a | input | REG_W | Younger op first source |
| yng_src_b | input | REG_W | Younger op second source |
| yng_dst | input | REG_W | Younger op destination |
| yng_grant | output | 1 | Younger op issues this cycle |
| yng_stall | output | 1 | Younger op held this cycle |
| sb_busy | output | 1 | An FP op is outstanding |
| sb_dst | output | REG_W | Destination of the outstanding FP op |
| exc_after_pass | output | 1 | Overtaken FP op completed with an exception |

## Verification
The bench builds the block with `REG_W` set to 3, so there are only eight register numbers. With so few, random operands collide with the outstanding entry often enough to exercise read-after-write, write-after-write and write-after-read hazards, and their combinations, many times. Directed sequences first cover each hazard class alone, each non-integer kind, completion in the same cycle as a grant, and an exception with and without a prior pass. A long random phase then mixes FP issues, completions and younger ops of every kind.

// File: rtl/ibi_pkg.sv
package ibi_pkg;
    typedef enum logic [2:0] {
        KIND_INT    = 3'd0,
        KIND_LOAD   = 3'd1,
        KIND_STORE  = 3'd2,
        KIND_BRANCH = 3'd3,
        KIND_FP     = 3'd4
    } op_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HELD   = 2'd1,
        ST_PASSED = 2'd2
    } slot_state_e;

    localparam int NUM_FP_SRC = 2;
endpackage

// File: rtl/ibi_scoreboard.sv
module ibi_scoreboard #(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [REG_W-1:0] in_dst,
    input  logic [REG_W-1:0] in_src_a,
    input  logic [REG_W-1:0] in_src_b,
    output logic [REG_W-1:0] held_dst,
    output logic [REG_W-1:0] held_src_a,
    output logic [REG_W-1:0] held_src_b
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_dst   <= '0;
            held_src_a <= '0;
            held_src_b <= '0;
        end else if (load) begin
            held_dst   <= in_dst;
            held_src_a <= in_src_a;
            held_src_b <= in_src_b;
        end
    end
endmodule

// File: rtl/ibi_hazard.sv
module ibi_hazard
    import ibi_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] held_dst,
    input  logic [REG_W-1:0] held_src_a,
    input  logic [REG_W-1:0] held_src_b,
    input  logic [REG_W-1:0] y_src_a,
    input  logic [REG_W-1:0] y_src_b,
    input  logic [REG_W-1:0] y_dst,
    output logic             conflict
);
    logic [NUM_FP_SRC-1:0] raw_hit;
    logic [NUM_FP_SRC-1:0] war_hit;
    logic [REG_W-1:0]      y_src   [NUM_FP_SRC];
    logic [REG_W-1:0]      h_src   [NUM_FP_SRC];
    logic                  waw_hit;

    assign y_src[0] = y_src_a;
    assign y_src[1] = y_src_b;
    assign h_src[0] = held_src_a;
    assign h_src[1] = held_src_b;

    for (genvar i = 0; i < NUM_FP_SRC; i++) begin : g_cmp
        assign raw_hit[i] = (y_src[i] == held_dst);
        assign war_hit[i] = (y_dst == h_src[i]);
    end

    assign waw_hit  = (y_dst == held_dst);
    assign conflict = (|raw_hit) || (|war_hit) || waw_hit;
endmodule

// File: rtl/ibi_ctrl.sv
module ibi_ctrl
    import ibi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fp_issue,
    input  logic fp_done,
    input  logic fp_exc,
    input  logic y_valid,
    input  logic y_is_int,
    input  logic conflict,
    output logic grant,
    output logic stall,
    output logic slot_free,
    output logic slot_busy,
    output logic load,
    output logic exc_pulse
);
    slot_state_e state_q, state_d;
    logic        exc_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            exc_pulse <= 1'b0;
        end else begin
            state_q   <= state_d;
            exc_pulse <= exc_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        grant     = 1'b0;
        load      = 1'b0;
        exc_d     = 1'b0;
        slot_free = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                slot_free = 1'b1;
                grant     = y_valid && !fp_issue;
                if (fp_issue) begin
                    load    = 1'b1;
                    state_d = ST_HELD;
                end
            end
            ST_HELD: begin
                grant = y_valid && y_is_int && !conflict;
                if (fp_done) begin
                    state_d = ST_IDLE;
                    exc_d   = fp_exc && grant;
                end else if (grant) begin
                    state_d = ST_PASSED;
                end
            end
            ST_PASSED: begin
                grant = y_valid && y_is_int && !conflict;
                if (fp_done) begin
                    state_d = ST_IDLE;
                    exc_d   = fp_exc;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign stall     = y_valid && !grant;
    assign slot_busy = (state_q != ST_IDLE);
endmodule

// File: rtl/indep_bypass_issue.sv
module indep_bypass_issue
    import ibi_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fp_issue,
    input  logic [REG_W-1:0] fp_dst,
    input  logic [REG_W-1:0] fp_src_a,
    input  logic [REG_W-1:0] fp_src_b,
    output logic             fp_ready,
    input  logic             fp_done,
    input  logic             fp_exc,
    input  logic             yng_valid,
    input  logic [2:0]       yng_kind,
    input  logic [REG_W-1:0] yng_src_a,
    input  logic [REG_W-1:0] yng_src_b,
    input  logic [REG_W-1:0] yng_dst,
    output logic             yng_grant,
    output logic             yng_stall,
    output logic             sb_busy,
    output logic [REG_W-1:0] sb_dst,
    output logic             exc_after_pass
);
    logic             load;
    logic             conflict;
    logic             is_int;
    logic [REG_W-1:0] h_src_a;
    logic [REG_W-1:0] h_src_b;

    assign is_int = (yng_kind == KIND_INT);

    ibi_scoreboard #(.REG_W(REG_W)) u_sb (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .in_dst     (fp_dst),
        .in_src_a   (fp_src_a),
        .in_src_b   (fp_src_b),
        .held_dst   (sb_dst),
        .held_src_a (h_src_a),
        .held_src_b (h_src_b)
    );

    ibi_hazard #(.REG_W(REG_W)) u_haz (
        .held_dst   (sb_dst),
        .held_src_a (h_src_a),
        .held_src_b (h_src_b),
        .y_src_a    (yng_src_a),
        .y_src_b    (yng_src_b),
        .y_dst      (yng_dst),
        .conflict   (conflict)
    );

    ibi_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .fp_issue  (fp_issue),
        .fp_done   (fp_done),
        .fp_exc    (fp_exc),
        .y_valid   (yng_valid),
        .y_is_int  (is_int),
        .conflict  (conflict),
        .grant     (yng_grant),
        .stall     (yng_stall),
        .slot_free (fp_ready),
        .slot_busy (sb_busy),
        .load      (load),
        .exc_pulse (exc_after_pass)
    );
endmodule

// File: rtl/ibi_checker.sv
module ibi_checker #(
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fp_issue,
    input logic [REG_W-1:0] fp_dst,
    input logic [REG_W-1:0] fp_src_a,
    input logic [REG_W-1:0] fp_src_b,
    input logic             fp_ready,
    input logic             fp_done,
    input logic             fp_exc,
    input logic             yng_valid,
    input logic [2:0]       yng_kind,
    input logic [REG_W-1:0] yng_src_a,
    input logic [REG_W-1:0] yng_src_b,
    input logic [REG_W-1:0] yng_dst,
    input logic             yng_grant,
    input logic             yng_stall,
    input logic             sb_busy,
    input logic [REG_W-1:0] sb_dst,
    input logic             exc_after_pass
);
    // Shadow of the sources accepted with the outstanding FP op
    logic [REG_W-1:0] cap_a, cap_b;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_a <= '0;
            cap_b <= '0;
        end else if (fp_issue && fp_ready) begin
            cap_a <= fp_src_a;
            cap_b <= fp_src_b;
        end
    end

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_issue && fp_ready) |=> (sb_busy && sb_dst == $past(fp_dst)));
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_busy && !fp_done) |=> (sb_busy && $stable(sb_dst)));
    p_idle_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (yng_valid && !sb_busy && !fp_issue) |-> yng_grant);
    p_busy_int_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_busy && yng_grant) |-> (yng_kind == 3'd0));
    p_no_raw_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_busy && yng_grant) |-> (yng_src_a != sb_dst && yng_src_b != sb_dst));
    p_no_waw_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_busy && yng_grant) |-> (yng_dst != sb_dst));
    p_no_war_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_busy && yng_grant) |-> (yng_dst != cap_a && yng_dst != cap_b));
    p_retire_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_busy && fp_done) |=> !sb_busy);
    p_exc_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_after_pass |-> ($past(fp_done && fp_exc && sb_busy) && !sb_busy));
    p_exc_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_after_pass |=> !exc_after_pass);
    p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({yng_grant, yng_stall}) && (yng_valid == (yng_grant || yng_stall)));
endmodule

bind indep_bypass_issue ibi_checker #(.REG_W(REG_W)) u_chk (.*);

// File: tb/indep_bypass_issue_test.sv
module indep_bypass_issue_test;
    localparam int RW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fp_issue = 0, fp_done = 0, fp_exc = 0, yng_valid = 0;
    logic [RW-1:0] fp_dst = 0, fp_src_a = 0, fp_src_b = 0;
    logic [RW-1:0] yng_src_a = 0, yng_src_b = 0, yng_dst = 0;
    logic [2:0]    yng_kind = 0;
    logic          fp_ready, yng_grant, yng_stall, sb_busy, exc_after_pass;
    logic [RW-1:0] sb_dst;

    int checks = 0;
    int fails  = 0;

    // Reference model state
    bit        m_busy = 0, m_passed = 0, m_exc = 0;
    bit [RW-1:0] m_dst = 0, m_sa = 0, m_sb = 0;

    always #10 clk = ~clk;

    indep_bypass_issue #(.REG_W(RW)) uut (.*);

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // One cycle: drive after the falling edge, compare, advance the model at the rising edge
    task automatic cyc(input bit fi, input int fd, input int fa, input int fb,
                       input bit dn, input bit ex,
                       input bit yv, input int yk, input int ya, input int yb, input int yd);
        bit    g;
        string why;
        @(negedge clk);
        fp_issue = fi; fp_dst = RW'(fd); fp_src_a = RW'(fa); fp_src_b = RW'(fb);
        fp_done = dn; fp_exc = ex;
        yng_valid = yv; yng_kind = 3'(yk);
        yng_src_a = RW'(ya); yng_src_b = RW'(yb); yng_dst = RW'(yd);
        #5;
        if (!m_busy) begin
            g   = yv && !fi;
            why = "R3";
        end else if (!yv) begin
            g = 0; why = "R11";
        end else if (yk != 0) begin
            g = 0; why = "R8";
        end else if (RW'(ya) == m_dst || RW'(yb) == m_dst) begin
            g = 0; why = "R5";
        end else if (RW'(yd) == m_dst) begin
            g = 0; why = "R6";
        end else if (RW'(yd) == m_sa || RW'(yd) == m_sb) begin
            g = 0; why = "R7";
        end else begin
            g = 1; why = "R4";
        end
        chk({why, " grant"}, yng_grant, g);
        chk("R11 stall", yng_stall, yv && !g);
        chk("R2 ready", fp_ready, !m_busy);
        chk("R9 busy", sb_busy, m_busy);
        if (m_busy) chk("R2 dst", sb_dst, m_dst);
        chk("R10 flag", exc_after_pass, m_exc);
        @(posedge clk);
        if (!m_busy) begin
            m_exc = 0;
            if (fi) begin
                m_busy = 1; m_passed = 0;
                m_dst = RW'(fd); m_sa = RW'(fa); m_sb = RW'(fb);
            end
        end else if (dn) begin
            m_busy = 0;
            m_exc  = ex && (m_passed || g);
        end else begin
            m_exc = 0;
            if (g) m_passed = 1;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=0 expected=1");
        summary();
    end

    initial begin
        #3;
        // R1: outputs during and right after reset
        chk("R1 busy", sb_busy, 0);
        chk("R1 ready", fp_ready, 1);
        chk("R1 grant", yng_grant, 0);
        chk("R1 flag", exc_after_pass, 0);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R3: idle grants any kind; FP issue in same cycle stalls
        cyc(0,0,0,0, 0,0, 1,2, 1,2,3);
        cyc(1,5,1,2, 0,0, 1,0, 6,6,6);      // R2 accept, R3 stall
        cyc(1,7,7,7, 0,0, 0,0, 0,0,0);      // R2 issue while busy ignored
        cyc(0,0,0,0, 0,0, 1,0, 3,4,6);      // R4 independent int
        cyc(0,0,0,0, 0,0, 1,0, 5,3,6);      // R5 raw on src a
        cyc(0,0,0,0, 0,0, 1,0, 3,5,6);      // R5 raw on src b
        cyc(0,0,0,0, 0,0, 1,0, 3,4,5);      // R6 waw
        cyc(0,0,0,0, 0,0, 1,0, 3,4,1);      // R7 war src a
        cyc(0,0,0,0, 0,0, 1,0, 3,4,2);      // R7 war src b
        for (int k = 1; k < 8; k++) cyc(0,0,0,0, 0,0, 1,k, 3,4,6); // R8
        cyc(0,0,0,0, 1,1, 1,5, 3,4,6);      // R10 retire after pass, flag
        cyc(0,0,0,0, 1,1, 0,0, 0,0,0);      // R9 done while idle ignored
        // R10: exception without pass gives no flag
        cyc(1,2,3,4, 0,0, 0,0, 0,0,0);
        cyc(0,0,0,0, 0,0, 1,0, 2,0,0);
        cyc(0,0,0,0, 1,1, 1,1, 0,0,0);
        cyc(0,0,0,0, 0,0, 0,0, 0,0,0);
        // R10/R9: grant in the completing cycle
        cyc(1,2,3,4, 0,0, 0,0, 0,0,0);
        cyc(0,0,0,0, 1,1, 1,0, 0,1,5);
        cyc(0,0,0,0, 0,0, 1,0, 2,2,2);

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            cyc(($urandom % 4) == 0, $urandom % 8, $urandom % 8, $urandom % 8,
                ($urandom % 5) == 0, ($urandom % 2) == 0,
                ($urandom % 4) != 0, (($urandom % 2) == 0) ? 0 : ($urandom % 8),
                $urandom % 8, $urandom % 8, $urandom % 8);
        end
        summary();
    end
endmodule